// File: doc/BRIEF.md
# Per-Channel Alarm Interrupt Controller

This block gathers the alarm conditions of a six-channel line-interface device and turns them into host-visible interrupt state. Every channel watches six sources: absence of pulses on its transmit output, receive loss of signal, receive loss of lock, jitter-buffer occupancy close to a limit, a PRBS error indication, and saturation of the PRBS error counter. Clock recovery, PRBS checking and the jitter buffer live elsewhere. Their alarm levels, the buffer occupancy and the jitter-attenuator enable arrive as inputs.

Each source sets a sticky status bit whenever its alarm condition changes, on entry and on exit. This happens only while the matching enable bit is set. A host on a byte-wide bus programs the enable bits and reads the status bits, and a read clears the status bits it returns. A single interrupt line is high while any channel holds a status bit whose enable bit is set. Two pieces of logic live inside the block. The first is a per-channel pulse-absence monitor, a two-state machine. In state `DM_SEEN` it counts idle cycles. The transition `SEEN->LOST` fires on the 128th consecutive idle cycle, and the transition `LOST->SEEN` fires on the next pulse. The second is a comparator that flags buffer occupancy near empty or near full.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: Channel n (0..5) has its enable register at byte address 0x01 + 0x10*n and its status register at 0x02 + 0x10*n. In both registers bit 0 is the pulse monitor, bit 1 loss of signal, bit 2 loss of lock, bit 3 buffer limit, bit 4 PRBS error and bit 5 PRBS saturation.
- R2: After reset every enable and status bit is 0, `irq` is 0 and `host_rdata` is 0x00.
- R3: A write to an enable address stores bits 5:0. A read returns them with bits 7:6 as 0, and writes to bits 7:6 are ignored.
- R4: Read data appears on `host_rdata` in the clock cycle after the read strobe. Unmapped addresses read 0x00. Writes to unmapped addresses or to status addresses change no register.
- R5: The pulse-monitor alarm of a channel rises after 128 consecutive sampled cycles with `tx_pulse` low. 127 idle cycles followed by a pulse raise no alarm, and any pulse ends the alarm.
- R6: The buffer-limit condition holds when `ja_enable` is 1 and occupancy is at most 2 or at least 30 (depth 32). While `ja_enable` is 0 the limit status bit cannot set and does not drive `irq`.
- R7: A status bit sets on every change of its alarm, both rising and falling, but only while its enable bit is set.
- R8: A status read clears the bits it returns. An event that lands in the same cycle as the read stays set for the next read.
- R9: `irq` is the OR over channels and sources of status AND enable. Clearing an enable bit drops `irq` without clearing the status bit.
- R10: An alarm held at a constant level produces exactly one status event. After that event is read, a further read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Bus access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Byte address, channel in bits 7:4 |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data, 0x00 when idle |
| tx_pulse | input | 6 | Transmit pulse seen this cycle, per channel |
| rx_los | input | 6 | Receive loss-of-signal level, per channel |
| rx_lol | input | 6 | Loss-of-lock level, per channel |
| ja_enable | input | 6 | Jitter attenuator active, per channel |
| fifo_occ | input | 36 | Buffer occupancy, 6 bits per channel, channel 0 in the low bits |
| prbs_err | input | 6 | PRBS error level, per channel |
| prbs_sat | input | 6 | PRBS error counter saturated, per channel |
| irq | output | 1 | Combined interrupt |

## Verification
A corrupted status bit shows up on the next status read, or at once as an `irq` that disagrees with the enable mask. A lost clear shows up as a non-zero value on a repeated read. A miscounting pulse monitor shows up two cycles after the 128th idle cycle: a status bit that is missing, or one that is present when the pulse arrived on cycle 127. An edge detector that fires more than once, or keeps firing, shows up on the read that follows a clearing read. The same-cycle read case separates a design that drops an arriving event from one that keeps it.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
    localparam int NSRC = 6;
    localparam int DW   = 8;

    typedef enum logic [2:0] {
        SRC_DMON = 3'd0,
        SRC_LOS  = 3'd1,
        SRC_LOL  = 3'd2,
        SRC_FLIM = 3'd3,
        SRC_PERR = 3'd4,
        SRC_PSAT = 3'd5
    } src_e;

    localparam logic [3:0] OFS_EN = 4'h1;
    localparam logic [3:0] OFS_ST = 4'h2;

    typedef enum logic {
        DM_SEEN = 1'b0,
        DM_LOST = 1'b1
    } dmon_state_e;
endpackage

// File: rtl/drv_pulse_mon.sv
module drv_pulse_mon
    import alarm_irq_pkg::*;
#(
    parameter int LIMIT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic alarm
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    dmon_state_e    state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DM_SEEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DM_SEEN: begin
                if (pulse) begin
                    cnt_d = '0;
                end else if (cnt_q == CW'(LIMIT - 1)) begin
                    state_d = DM_LOST;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            DM_LOST: begin
                if (pulse) begin
                    state_d = DM_SEEN;
                end
            end
            default: state_d = DM_SEEN;
        endcase
    end

    always_comb begin
        alarm = (state_q == DM_LOST);
    end

    // R5
    dmon_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !alarm);

    // R5
    dmon_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(!pulse));
endmodule

// File: rtl/fifo_limit_cmp.sv
module fifo_limit_cmp #(
    parameter int DEPTH  = 32,
    parameter int MARGIN = 2,
    parameter int OCC_W  = $clog2(DEPTH + 1)
) (
    input  logic [OCC_W-1:0] occ,
    input  logic             ja_en,
    output logic             near
);
    localparam logic [OCC_W-1:0] LOW_MARK  = OCC_W'(MARGIN);
    localparam logic [OCC_W-1:0] HIGH_MARK = OCC_W'(DEPTH - MARGIN);

    always_comb begin
        near = ja_en && ((occ <= LOW_MARK) || (occ >= HIGH_MARK));
    end
endmodule

// File: rtl/chan_alarm_regs.sv
module chan_alarm_regs
    import alarm_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] alarm_raw,
    input  logic            ja_en,
    input  logic            en_wr,
    input  logic [NSRC-1:0] wdata,
    input  logic            rd_clr,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] st_q,
    output logic            irq_ch
);
    logic [NSRC-1:0] alm_q, alm_p, en_eff, evt, st_d, gate;
    logic            ja_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_q <= '0;
            alm_p <= '0;
            ja_q  <= 1'b0;
            en_q  <= '0;
            st_q  <= '0;
        end else begin
            alm_q <= alarm_raw;
            alm_p <= alm_q;
            ja_q  <= ja_en;
            if (en_wr) en_q <= wdata;
            st_q  <= st_d;
        end
    end

    always_comb begin
        gate = '1;
        gate[int'(SRC_FLIM)] = ja_q;
        en_eff = en_q & gate;
        evt    = (alm_q ^ alm_p) & en_eff;
        st_d   = (rd_clr ? '0 : st_q) | evt;
        irq_ch = |(st_q & en_eff);
    end

    // R7
    st_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q & ~$past(st_q) & ~$past(en_eff)) == '0);

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (evt == '0)) |=> (st_q == '0));
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int NUM_CH      = 6,
    parameter int DMON_LIMIT  = 128,
    parameter int FIFO_DEPTH  = 32,
    parameter int FIFO_MARGIN = 2,
    parameter int OCC_W       = $clog2(FIFO_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_sel,
    input  logic                    host_wr,
    input  logic [7:0]              host_addr,
    input  logic [7:0]              host_wdata,
    output logic [7:0]              host_rdata,
    input  logic [NUM_CH-1:0]       tx_pulse,
    input  logic [NUM_CH-1:0]       rx_los,
    input  logic [NUM_CH-1:0]       rx_lol,
    input  logic [NUM_CH-1:0]       ja_enable,
    input  logic [NUM_CH*OCC_W-1:0] fifo_occ,
    input  logic [NUM_CH-1:0]       prbs_err,
    input  logic [NUM_CH-1:0]       prbs_sat,
    output logic                    irq
);
    localparam int PAD = DW - NSRC;

    logic [3:0]        ch_sel, ofs;
    logic              host_rd, hit_any;
    logic [NUM_CH-1:0] hit_en, hit_st, irq_ch, dm_alarm, near;
    logic [NSRC-1:0]   en_all [NUM_CH];
    logic [NSRC-1:0]   st_all [NUM_CH];
    logic [NSRC-1:0]   raw    [NUM_CH];
    logic [DW-1:0]     rd_mux;
    logic              unused_wbits;

    assign ch_sel       = host_addr[7:4];
    assign ofs          = host_addr[3:0];
    assign host_rd      = host_sel && !host_wr;
    assign unused_wbits = ^host_wdata[DW-1:NSRC];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign hit_en[c] = host_sel && (ch_sel == 4'(c)) && (ofs == OFS_EN);
        assign hit_st[c] = host_sel && (ch_sel == 4'(c)) && (ofs == OFS_ST);

        drv_pulse_mon #(.LIMIT(DMON_LIMIT)) u_dmon (
            .clk   (clk),
            .rst_n (rst_n),
            .pulse (tx_pulse[c]),
            .alarm (dm_alarm[c])
        );

        fifo_limit_cmp #(.DEPTH(FIFO_DEPTH), .MARGIN(FIFO_MARGIN), .OCC_W(OCC_W)) u_flim (
            .occ   (fifo_occ[c*OCC_W +: OCC_W]),
            .ja_en (ja_enable[c]),
            .near  (near[c])
        );

        always_comb begin
            raw[c] = '0;
            raw[c][int'(SRC_DMON)] = dm_alarm[c];
            raw[c][int'(SRC_LOS)]  = rx_los[c];
            raw[c][int'(SRC_LOL)]  = rx_lol[c];
            raw[c][int'(SRC_FLIM)] = near[c];
            raw[c][int'(SRC_PERR)] = prbs_err[c];
            raw[c][int'(SRC_PSAT)] = prbs_sat[c];
        end

        chan_alarm_regs u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .alarm_raw (raw[c]),
            .ja_en     (ja_enable[c]),
            .en_wr     (hit_en[c] && host_wr),
            .wdata     (host_wdata[NSRC-1:0]),
            .rd_clr    (hit_st[c] && !host_wr),
            .en_q      (en_all[c]),
            .st_q      (st_all[c]),
            .irq_ch    (irq_ch[c])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit_en[c]) rd_mux = rd_mux | {{PAD{1'b0}}, en_all[c]};
            if (hit_st[c]) rd_mux = rd_mux | {{PAD{1'b0}}, st_all[c]};
        end
        hit_any = |{hit_en, hit_st};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) host_rdata <= '0;
        else        host_rdata <= host_rd ? rd_mux : '0;
    end

    assign irq = |irq_ch;

    // R4
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !hit_any) |=> (host_rdata == 8'h00));
endmodule

// File: tb/tb_alarm_irq_ctrl.sv
module tb_alarm_irq_ctrl;
    localparam int NUM_CH = 6;
    localparam int OCC_W  = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                    rst_n;
    logic                    host_sel, host_wr;
    logic [7:0]              host_addr, host_wdata, host_rdata;
    logic [NUM_CH-1:0]       tx_pulse, rx_los, rx_lol, ja_enable, prbs_err, prbs_sat;
    logic [NUM_CH*OCC_W-1:0] fifo_occ;
    logic                    irq;

    alarm_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_pulse(tx_pulse), .rx_los(rx_los), .rx_lol(rx_lol),
        .ja_enable(ja_enable), .fifo_occ(fifo_occ), .prbs_err(prbs_err),
        .prbs_sat(prbs_sat), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always @(posedge clk) rd_seen <= rst_n && host_sel && !host_wr;

    // Monitor: pops one expected item per read and compares it
    always @(negedge clk) begin : mon
        logic [7:0] e;
        string t;
        if (rd_seen && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (host_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata=%02h expected %02h", t, host_rdata, e);
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    // Driver: pushes expected value, issues read, leaves a cycle for the monitor
    task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        @(negedge clk);
        host_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_irq(input logic exp, input string tag);
        n_chk++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s: irq=%0b expected %0b", tag, irq, exp);
        end
    endtask

    task automatic set_occ(input int ch, input logic [OCC_W-1:0] v);
        fifo_occ[ch*OCC_W +: OCC_W] = v;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        rst_n = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
        tx_pulse = '1; rx_los = '0; rx_lol = '0; ja_enable = '1;
        prbs_err = '0; prbs_sat = '0;
        fifo_occ = {NUM_CH{6'd16}};
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R2 reset state
        n_chk++;
        if (host_rdata !== 8'h00) begin
            n_fail++;
            $display("FAIL R2: rdata=%02h expected 00", host_rdata);
        end
        check_irq(1'b0, "R2 irq after reset");
        do_read(8'h01, 8'h00, "R2 enable ch0 reset");
        do_read(8'h02, 8'h00, "R2 status ch0 reset");
        do_read(8'h52, 8'h00, "R2 status ch5 reset");

        // R3 enable read/write, reserved bits
        do_write(8'h01, 8'hFF);
        do_read(8'h01, 8'h3F, "R3 enable ch0 reserved bits");
        do_write(8'h41, 8'hC5);
        do_read(8'h41, 8'h05, "R3 R1 enable ch4 address");

        // R4 unmapped and status writes
        do_write(8'h12, 8'hFF);
        do_read(8'h12, 8'h00, "R4 status write ignored");
        do_read(8'h11, 8'h00, "R4 ch1 enable untouched");
        do_write(8'h61, 8'hFF);
        do_read(8'h61, 8'h00, "R4 unmapped ch6");
        do_read(8'h03, 8'h00, "R4 unmapped offset 3");
        do_read(8'h00, 8'h00, "R4 unmapped offset 0");
        do_read(8'h11, 8'h00, "R4 unmapped write no leak");

        // R7 R9 R10 loss of signal on ch0 (bit 1)
        rx_los[0] = 1'b1;
        wait_n(3);
        check_irq(1'b1, "R9 irq on ch0 los");
        do_read(8'h02, 8'h02, "R7 R1 los rise bit1");
        check_irq(1'b0, "R8 irq after clear");
        do_read(8'h02, 8'h00, "R10 steady alarm one event");
        rx_los[0] = 1'b0;
        wait_n(3);
        do_read(8'h02, 8'h02, "R7 los fall sets again");

        // R7 disabled source does not latch
        rx_lol[2] = 1'b1; wait_n(3);
        rx_lol[2] = 1'b0; wait_n(3);
        do_read(8'h22, 8'h00, "R7 disabled lol no latch");
        do_write(8'h21, 8'h04);
        wait_n(2);
        do_read(8'h22, 8'h00, "R7 enable later no stale");
        check_irq(1'b0, "R7 irq idle");

        // R5 pulse monitor on ch3 (bit 0)
        do_write(8'h31, 8'h01);
        tx_pulse[3] = 1'b0;
        wait_n(127);
        tx_pulse[3] = 1'b1;
        wait_n(4);
        do_read(8'h32, 8'h00, "R5 127 idle cycles no alarm");
        tx_pulse[3] = 1'b0;
        wait_n(128);
        wait_n(3);
        do_read(8'h32, 8'h01, "R5 128 idle cycles alarm");
        tx_pulse[3] = 1'b1;
        wait_n(3);
        do_read(8'h32, 8'h01, "R5 pulse ends alarm");

        // R6 buffer limit on ch4 (bit 3)
        do_write(8'h41, 8'h3F);
        set_occ(4, 6'd2);  wait_n(3);
        do_read(8'h42, 8'h08, "R6 occ 2 near empty");
        set_occ(4, 6'd3);  wait_n(3);
        do_read(8'h42, 8'h08, "R6 occ 3 leaves limit");
        set_occ(4, 6'd29); wait_n(3);
        do_read(8'h42, 8'h00, "R6 occ 29 not near");
        set_occ(4, 6'd30); wait_n(3);
        do_read(8'h42, 8'h08, "R6 occ 30 near full");
        ja_enable[4] = 1'b0; wait_n(3);
        do_read(8'h42, 8'h00, "R6 ja off masks change");
        check_irq(1'b0, "R6 irq with ja off");
        set_occ(4, 6'd0);  wait_n(3);
        do_read(8'h42, 8'h00, "R6 ja off occ 0");
        ja_enable[4] = 1'b1; wait_n(3);
        do_read(8'h42, 8'h08, "R6 ja on at occ 0");

        // R8 event in the same cycle as the read, ch5
        do_write(8'h51, 8'h3F);
        prbs_sat[5] = 1'b1;
        wait_n(3);
        prbs_err[5] = 1'b1;
        wait_n(1);
        do_read(8'h52, 8'h20, "R8 read returns saturation");
        do_read(8'h52, 8'h10, "R8 same-cycle event kept");
        check_irq(1'b0, "R8 irq after reads");

        // R9 enable gates irq without clearing status, ch1
        do_write(8'h11, 8'h02);
        rx_los[1] = 1'b1;
        wait_n(3);
        check_irq(1'b1, "R9 irq set ch1");
        do_write(8'h11, 8'h00);
        check_irq(1'b0, "R9 enable cleared drops irq");
        do_write(8'h11, 8'h02);
        check_irq(1'b1, "R9 status kept irq returns");
        do_read(8'h12, 8'h02, "R9 status still held");
        check_irq(1'b0, "R9 irq after read");

        wait_n(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule